// File: doc/BRIEF.md
# Three-Wire Serial Register Slave

This block is the device side of a small control port that shares one bidirectional data wire between host and slave, next to a chip select and a serial clock. The host opens each transfer with a header made of a six-bit register address and a direction flag. A write then carries one data byte from the host. A read leaves one clock with nobody on the wire, and the slave then drives back one byte. The shared pin is split into a data input, a data output and an output enable, and a pad ring joins them.

Four registers sit behind the port. The first is a free scratch byte the host uses to test the link. The second is a fixed identity byte made of a chip code and a revision code. The third holds a three-bit resolution code. The fourth holds a power bit and a bit that chooses who controls resolution and power: the registers, or two pins on the block. The serial lines are brought into the system clock domain through synchronizers. Edges of the serial clock are found there, so all state runs on one clock.

Top module: `spi3w_regslave`

## Requirements
- R1: A transfer is a stream of bits, MSB first, clocked in on rising serial-clock edges while `selN` is low. Clocks 1 to 6 carry address bits 5 down to 0, and clock 7 carries the direction (1 = read, 0 = write). On a write, clock 8 is a pad bit whose value has no effect.
- R2: On a write, clocks 9 to 16 carry the data byte MSB first. The register is updated only when the 16th rising edge has been seen.
- R3: On a read, `dOutEn` stays low through clocks 1 to 8, so clock 8 is a turnaround with the wire undriven. After the falling edge of clock 8 the slave drives the register value MSB first for clocks 9 to 16. It changes `dOut` only after falling edges, so each bit is stable across its rising edge.
- R4: Address 0x00 is a scratch byte: any value written there reads back unchanged.
- R5: Address 0x01 reads as `{CHIP_ID, CHIP_VER}` (upper nibble identity, lower nibble revision; defaults 0x1 and 0x2, so 0x12). Writes to it change nothing.
- R6: Address 0x02 holds a resolution code in bits 2:0 and reads 0 in bits 7:3. Written codes 0, 1, 4, 5, 6 and 7 are stored. Codes 2 and 3 are illegal, and writing one of them leaves the stored code unchanged.
- R7: Address 0x03 holds a power bit at bit 0 (1 = active, 0 = standby) and a control-select bit at bit 7 (1 = registers, 0 = pins). Its other bits read 0.
- R8: When bit 7 of 0x03 is 1, `resSel` equals the stored code and `powerOn` equals bit 0 of 0x03. When it is 0, they follow `resPin` and `pwrPin`.
- R9: If `selN` rises before the 16th rising edge, the transfer ends and no register changes. `dOutEn` falls within a few system clocks of `selN` going high.
- R10: Writes to addresses 0x04 to 0x3F change no register, and reads of those addresses return 0x00.
- R11: While `rstN` is low, the registers return to their defaults: 0x00 scratch, resolution code `RES_DEFAULT` (7), 0x00 at 0x03, and `dOutEn` low.
- R12: Serial clocks after the 16th are ignored. They cause no second write, and on a read `dOutEn` is low again after the falling edge of clock 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state runs on it |
| rstN | input | 1 | Asynchronous active-low reset |
| serClk | input | 1 | Serial clock from the host, idle low |
| selN | input | 1 | Active-low chip select |
| dIn | input | 1 | Data wire as seen by the slave |
| dOut | output | 1 | Data the slave puts on the wire |
| dOutEn | output | 1 | Output enable for the data wire |
| resPin | input | 3 | Resolution code when the pins are in control |
| pwrPin | input | 1 | Power state when the pins are in control |
| resSel | output | 3 | Resolution code in effect |
| powerOn | output | 1 | Power state in effect (1 = active) |

## Verification
The bench looks at the output enable clock by clock. A slave that drove during the turnaround clock, or that started one clock late, would show up as a wrong enable pattern or as a byte shifted by one bit. Transfers are cut short at the 15th clock, and a write with 24 clocks is sent. Together these catch a commit one edge too early or a second commit from the extra bits. Writes to the identity register, of the illegal resolution codes 2 and 3, and to address 0x20 are each followed by read-backs. An address decoder that dropped the top bit, or a field with no legality filter, would change a value the bench expects to be unchanged.

// File: rtl/spi3w_pkg.sv
package spi3w_pkg;

  localparam int ADDR_W    = 6;
  localparam int DATA_W    = 8;
  localparam int RES_W     = 3;
  localparam int XFER_BITS = ADDR_W + 2 + DATA_W;
  localparam int CNT_W     = $clog2(XFER_BITS + 1);

  localparam int PWR_BIT = 0;
  localparam int SW_BIT  = DATA_W - 1;

  localparam logic [ADDR_W-1:0] ADDR_SCRATCH = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_IDENT   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_RESCTL  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] ADDR_PWRCTL  = ADDR_W'(3);

  // strobes from the serial control to the register datapath
  typedef struct packed {
    logic clear;
    logic addrShift;
    logic dataShift;
    logic commitWr;
    logic loadRd;
    logic shiftOut;
    logic bitIn;
  } strobe_t;

endpackage

// File: rtl/spi3w_ctrl.sv
module spi3w_ctrl
  import spi3w_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    serClk,
  input  logic    selN,
  input  logic    dIn,
  output strobe_t st,
  output logic    driveEn
);

  localparam logic [CNT_W-1:0] CNT_DIR  = CNT_W'(ADDR_W);
  localparam logic [CNT_W-1:0] CNT_DATA = CNT_W'(ADDR_W + 2);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(XFER_BITS - 1);
  localparam logic [CNT_W-1:0] CNT_DONE = CNT_W'(XFER_BITS);

  logic [SYNC_STAGES-1:0] clkSync, selSync, datSync;

  generate
    if (SYNC_STAGES > 1) begin : g_sync_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          clkSync <= '0;
          selSync <= '1;
          datSync <= '0;
        end else begin
          clkSync <= {clkSync[SYNC_STAGES-2:0], serClk};
          selSync <= {selSync[SYNC_STAGES-2:0], selN};
          datSync <= {datSync[SYNC_STAGES-2:0], dIn};
        end
      end
    end else begin : g_sync_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          clkSync <= '0;
          selSync <= '1;
          datSync <= '0;
        end else begin
          clkSync <= serClk;
          selSync <= selN;
          datSync <= dIn;
        end
      end
    end
  endgenerate

  logic clkS, selS, datS, clkPrev;
  assign clkS = clkSync[SYNC_STAGES-1];
  assign selS = selSync[SYNC_STAGES-1];
  assign datS = datSync[SYNC_STAGES-1];

  logic riseEvt, fallEvt;
  assign riseEvt = clkS & ~clkPrev & ~selS;
  assign fallEvt = ~clkS & clkPrev & ~selS;

  logic [CNT_W-1:0] bitCnt;
  logic             isRead;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkPrev <= 1'b0;
      bitCnt  <= '0;
      isRead  <= 1'b0;
      driveEn <= 1'b0;
    end else begin
      clkPrev <= clkS;
      if (selS) begin
        bitCnt  <= '0;
        isRead  <= 1'b0;
        driveEn <= 1'b0;
      end else begin
        if (riseEvt && bitCnt < CNT_DONE) begin
          bitCnt <= bitCnt + 1'b1;
          if (bitCnt == CNT_DIR) isRead <= datS;
        end
        if (st.loadRd) driveEn <= 1'b1;
        else if (fallEvt && bitCnt == CNT_DONE) driveEn <= 1'b0;
      end
    end
  end

  always_comb begin
    st           = '0;
    st.clear     = selS;
    st.bitIn     = datS;
    st.addrShift = riseEvt && (bitCnt < CNT_DIR);
    st.dataShift = riseEvt && !isRead && (bitCnt >= CNT_DATA) && (bitCnt < CNT_DONE);
    st.commitWr  = riseEvt && !isRead && (bitCnt == CNT_LAST);
    st.loadRd    = fallEvt && isRead && (bitCnt == CNT_DATA);
    st.shiftOut  = fallEvt && isRead && (bitCnt > CNT_DATA) && (bitCnt < CNT_DONE);
  end

  // R9: deselect releases the wire
  a_r9_release_on_deselect: assert property (@(posedge clk) disable iff (!rstN)
    selS |=> !driveEn);
  // R3: never drive before the turnaround clock has passed on a read
  a_r3_no_drive_early: assert property (@(posedge clk) disable iff (!rstN)
    driveEn |-> (isRead && bitCnt >= CNT_DATA));
  // R3: drive begins only after a falling serial edge
  a_r3_drive_after_fall: assert property (@(posedge clk) disable iff (!rstN)
    $rose(driveEn) |-> $past(fallEvt));
  // R2: commits only inside a selected write
  a_r2_commit_selected: assert property (@(posedge clk) disable iff (!rstN)
    st.commitWr |-> (!selS && !isRead));
  // R12: after the commit the counter is parked at its end
  a_r12_single_commit: assert property (@(posedge clk) disable iff (!rstN)
    st.commitWr |=> (bitCnt == CNT_DONE && !st.commitWr));

endmodule

// File: rtl/spi3w_datapath.sv
module spi3w_datapath
  import spi3w_pkg::*;
#(
  parameter logic [3:0]       CHIP_ID     = 4'h1,
  parameter logic [3:0]       CHIP_VER    = 4'h2,
  parameter logic [RES_W-1:0] RES_DEFAULT = 3'd7
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          st,
  input  logic [RES_W-1:0] resPin,
  input  logic             pwrPin,
  output logic             outBit,
  output logic [RES_W-1:0] resSel,
  output logic             powerOn
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ, outQ, scratchQ, rdByte, wrByte;
  logic [RES_W-1:0]  resQ;
  logic              pwrQ, swQ;

  assign wrByte = {dataQ[DATA_W-2:0], st.bitIn};

  function automatic logic resLegal(input logic [RES_W-1:0] code);
    return (code != RES_W'(2)) && (code != RES_W'(3));
  endfunction

  always_comb begin
    rdByte = '0;
    case (addrQ)
      ADDR_SCRATCH: rdByte = scratchQ;
      ADDR_IDENT:   rdByte = DATA_W'({CHIP_ID, CHIP_VER});
      ADDR_RESCTL:  rdByte[RES_W-1:0] = resQ;
      ADDR_PWRCTL: begin
        rdByte[PWR_BIT] = pwrQ;
        rdByte[SW_BIT]  = swQ;
      end
      default:      rdByte = '0;
    endcase
  end

  // serial shift registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
      outQ  <= '0;
    end else if (st.clear) begin
      addrQ <= '0;
      dataQ <= '0;
      outQ  <= '0;
    end else begin
      if (st.addrShift) addrQ <= {addrQ[ADDR_W-2:0], st.bitIn};
      if (st.dataShift) dataQ <= wrByte;
      if (st.loadRd)        outQ <= rdByte;
      else if (st.shiftOut) outQ <= {outQ[DATA_W-2:0], 1'b0};
    end
  end

  // register file
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scratchQ <= '0;
      resQ     <= RES_DEFAULT;
      pwrQ     <= 1'b0;
      swQ      <= 1'b0;
    end else if (st.commitWr) begin
      case (addrQ)
        ADDR_SCRATCH: scratchQ <= wrByte;
        ADDR_RESCTL:  if (resLegal(wrByte[RES_W-1:0])) resQ <= wrByte[RES_W-1:0];
        ADDR_PWRCTL: begin
          pwrQ <= wrByte[PWR_BIT];
          swQ  <= wrByte[SW_BIT];
        end
        default: ;
      endcase
    end
  end

  assign outBit  = outQ[DATA_W-1];
  assign resSel  = swQ ? resQ : resPin;
  assign powerOn = swQ ? pwrQ : pwrPin;

  // R6: the stored code is never one of the illegal ones
  a_r6_res_code_legal: assert property (@(posedge clk) disable iff (!rstN)
    (resQ != RES_W'(2)) && (resQ != RES_W'(3)));
  // R10: commits to unmapped addresses leave every register alone
  a_r10_unmapped_no_effect: assert property (@(posedge clk) disable iff (!rstN)
    (st.commitWr && addrQ > ADDR_PWRCTL) |=>
      ($stable(scratchQ) && $stable(resQ) && $stable(pwrQ) && $stable(swQ)));
  // R5: commits to the identity address leave every register alone
  a_r5_ident_readonly: assert property (@(posedge clk) disable iff (!rstN)
    (st.commitWr && addrQ == ADDR_IDENT) |=>
      ($stable(scratchQ) && $stable(resQ) && $stable(pwrQ) && $stable(swQ)));

endmodule

// File: rtl/spi3w_regslave.sv
module spi3w_regslave
  import spi3w_pkg::*;
#(
  parameter int               SYNC_STAGES = 2,
  parameter logic [3:0]       CHIP_ID     = 4'h1,
  parameter logic [3:0]       CHIP_VER    = 4'h2,
  parameter logic [RES_W-1:0] RES_DEFAULT = 3'd7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             serClk,
  input  logic             selN,
  input  logic             dIn,
  output logic             dOut,
  output logic             dOutEn,
  input  logic [RES_W-1:0] resPin,
  input  logic             pwrPin,
  output logic [RES_W-1:0] resSel,
  output logic             powerOn
);

  strobe_t st;
  logic    driveEn, outBit;

  spi3w_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .serClk  (serClk),
    .selN    (selN),
    .dIn     (dIn),
    .st      (st),
    .driveEn (driveEn)
  );

  spi3w_datapath #(
    .CHIP_ID     (CHIP_ID),
    .CHIP_VER    (CHIP_VER),
    .RES_DEFAULT (RES_DEFAULT)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .st      (st),
    .resPin  (resPin),
    .pwrPin  (pwrPin),
    .outBit  (outBit),
    .resSel  (resSel),
    .powerOn (powerOn)
  );

  assign dOutEn = driveEn;
  assign dOut   = driveEn & outBit;

endmodule

// File: tb/spi3w_regslave_tb.sv
module spi3w_regslave_tb;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       serClk = 1'b0;
  logic       selN = 1'b1;
  logic       dIn = 1'b0;
  logic       dOut, dOutEn;
  logic [2:0] resPin = 3'd4;
  logic       pwrPin = 1'b1;
  logic [2:0] resSel;
  logic       powerOn;

  int nChecks = 0;
  int nErrors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi3w_regslave u_dut (
    .clk(clk), .rstN(rstN), .serClk(serClk), .selN(selN), .dIn(dIn),
    .dOut(dOut), .dOutEn(dOutEn), .resPin(resPin), .pwrPin(pwrPin),
    .resSel(resSel), .powerOn(powerOn)
  );

  task automatic waitClk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic spiXfer(input logic [31:0] tx, input int nClk,
                         output logic [31:0] rxLo, output logic [31:0] rxHi,
                         output logic [31:0] oeLo, output logic endOe,
                         output logic oeAfterSel);
    rxLo = '0; rxHi = '0; oeLo = '0;
    selN = 1'b0;
    waitClk(HALF);
    for (int k = 0; k < nClk; k++) begin
      dIn = tx[31-k];
      waitClk(HALF-1);
      rxLo[31-k] = dOut;
      oeLo[31-k] = dOutEn;
      waitClk(1);
      serClk = 1'b1;
      waitClk(HALF/2);
      rxHi[31-k] = dOut;
      waitClk(HALF/2);
      serClk = 1'b0;
    end
    waitClk(HALF);
    endOe = dOutEn;
    selN = 1'b1;
    dIn = 1'b0;
    waitClk(6);
    oeAfterSel = dOutEn;
    waitClk(4);
  endtask

  task automatic wrReg(input logic [5:0] addr, input logic [7:0] data, input logic pad = 1'b0);
    logic [31:0] a, b, c;
    logic d, e;
    spiXfer({addr, 1'b0, pad, data, 16'h0}, 16, a, b, c, d, e);
  endtask

  task automatic rdReg(input logic [5:0] addr, output logic [7:0] data);
    logic [31:0] lo, hi, oe;
    logic d, e;
    spiXfer({addr, 1'b1, 1'b0, 24'h0}, 16, lo, hi, oe, d, e);
    data = lo[23:16];
  endtask

  task automatic rdChk(input string tag, input logic [5:0] addr, input logic [7:0] exp);
    logic [7:0] v;
    rdReg(addr, v);
    check(tag, {24'h0, v}, {24'h0, exp});
  endtask

  task automatic testReset();
    check("R11 dOutEn low after reset", {31'h0, dOutEn}, 32'h0);
    check("R8 pins in control after reset", {28'h0, resSel, powerOn}, {28'h0, 3'd4, 1'b1});
    rdChk("R11 scratch default", 6'h00, 8'h00);
    rdChk("R11 resolution default", 6'h02, 8'h07);
    rdChk("R11 power control default", 6'h03, 8'h00);
  endtask

  task automatic testScratch();
    wrReg(6'h00, 8'h55);
    rdChk("R4 scratch 0x55", 6'h00, 8'h55);
    wrReg(6'h00, 8'hA3);
    rdChk("R4 R2 scratch 0xA3", 6'h00, 8'hA3);
    wrReg(6'h00, 8'h66, 1'b1);
    rdChk("R1 pad bit ignored", 6'h00, 8'h66);
  endtask

  task automatic testIdent();
    rdChk("R5 identity byte", 6'h01, 8'h12);
    wrReg(6'h01, 8'hFF);
    rdChk("R5 identity after write", 6'h01, 8'h12);
    rdChk("R5 scratch untouched", 6'h00, 8'h66);
  endtask

  task automatic testResolution();
    wrReg(6'h02, 8'h05);
    rdChk("R6 code 5 stored", 6'h02, 8'h05);
    wrReg(6'h02, 8'h03);
    rdChk("R6 code 3 rejected", 6'h02, 8'h05);
    wrReg(6'h02, 8'hFA);
    rdChk("R6 code 2 rejected", 6'h02, 8'h05);
    wrReg(6'h02, 8'hF9);
    rdChk("R6 code 1 stored, upper bits zero", 6'h02, 8'h01);
    wrReg(6'h02, 8'h00);
    rdChk("R6 code 0 stored", 6'h02, 8'h00);
    wrReg(6'h02, 8'h06);
  endtask

  task automatic testPower();
    wrReg(6'h03, 8'hFF);
    rdChk("R7 only bits 7 and 0 kept", 6'h03, 8'h81);
    check("R8 register control", {28'h0, resSel, powerOn}, {28'h0, 3'd6, 1'b1});
    wrReg(6'h03, 8'h80);
    check("R8 register standby", {31'h0, powerOn}, 32'h0);
    pwrPin = 1'b0;
    resPin = 3'd5;
    wrReg(6'h03, 8'h01);
    rdChk("R7 power bit only", 6'h03, 8'h01);
    check("R8 pins back in control", {28'h0, resSel, powerOn}, {28'h0, 3'd5, 1'b0});
  endtask

  task automatic testAbort();
    logic [31:0] lo, hi, oe;
    logic endOe, oeSel;
    wrReg(6'h00, 8'h55);
    spiXfer({6'h00, 2'b00, 8'h99, 16'h0}, 15, lo, hi, oe, endOe, oeSel);
    rdChk("R9 write aborted at clock 15", 6'h00, 8'h55);
    spiXfer({6'h02, 2'b00, 8'h04, 16'h0}, 15, lo, hi, oe, endOe, oeSel);
    rdChk("R9 resolution unchanged after abort", 6'h02, 8'h06);
    spiXfer({6'h00, 1'b1, 1'b0, 24'h0}, 11, lo, hi, oe, endOe, oeSel);
    check("R9 driving before deselect", {31'h0, oe[21]}, 32'h1);
    check("R9 released after deselect", {31'h0, oeSel}, 32'h0);
  endtask

  task automatic testUnmapped();
    wrReg(6'h3F, 8'hAB);
    rdChk("R10 read 0x3F", 6'h3F, 8'h00);
    rdChk("R10 read 0x04", 6'h04, 8'h00);
    wrReg(6'h20, 8'h11);
    rdChk("R10 0x20 does not alias scratch", 6'h00, 8'h55);
    wrReg(6'h22, 8'h04);
    rdChk("R10 0x22 does not alias resolution", 6'h02, 8'h06);
  endtask

  task automatic testTurnaround();
    logic [31:0] lo, hi, oe;
    logic endOe, oeSel;
    wrReg(6'h00, 8'hB4);
    spiXfer({6'h00, 1'b1, 1'b0, 24'h0}, 16, lo, hi, oe, endOe, oeSel);
    check("R3 no drive in header and turnaround", {24'h0, oe[31:24]}, 32'h0);
    check("R3 drive during data clocks", {24'h0, oe[23:16]}, 32'hFF);
    check("R3 data MSB first", {24'h0, lo[23:16]}, 32'hB4);
    check("R3 bits stable across rising edge", {24'h0, hi[23:16]}, {24'h0, lo[23:16]});
    check("R12 released after last fall", {31'h0, endOe}, 32'h0);
  endtask

  task automatic testOverrun();
    logic [31:0] lo, hi, oe;
    logic endOe, oeSel;
    spiXfer({6'h00, 2'b00, 8'h3C, 8'hC3, 8'h00}, 24, lo, hi, oe, endOe, oeSel);
    rdChk("R12 no second write", 6'h00, 8'h3C);
    spiXfer({6'h01, 1'b1, 1'b0, 24'h0}, 20, lo, hi, oe, endOe, oeSel);
    check("R12 read data with extra clocks", {24'h0, lo[23:16]}, 32'h12);
    check("R12 no drive on extra clocks", {28'h0, oe[15:12]}, 32'h0);
  endtask

  task automatic testResetMid();
    wrReg(6'h03, 8'h81);
    rstN = 1'b0;
    waitClk(4);
    check("R11 dOutEn low in reset", {31'h0, dOutEn}, 32'h0);
    rstN = 1'b1;
    waitClk(4);
    rdChk("R11 scratch cleared by reset", 6'h00, 8'h00);
    rdChk("R11 resolution restored", 6'h02, 8'h07);
    rdChk("R11 control cleared", 6'h03, 8'h00);
  endtask

  initial begin
    waitClk(5);
    rstN = 1'b1;
    waitClk(5);
    testReset();
    testScratch();
    testIdent();
    testResolution();
    testPower();
    testAbort();
    testUnmapped();
    testTurnaround();
    testOverrun();
    testResetMid();
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    nChecks++;
    nErrors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule